// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds a frame transmitter from a circular list of descriptors kept in shared memory. Software fills a descriptor with a buffer pointer and a length, sets the ownership flag and strobes a demand. The engine then fetches the descriptor, streams the buffer one byte per cycle, writes the descriptor back with ownership returned to software, and moves on to the next entry. It keeps going until it meets a descriptor that software still owns. It then stays idle until the next demand.

Memory is 16 bits wide and word addressed. The engine issues single-word reads and writes. A read is answered by a one-cycle valid pulse that carries the data. Each descriptor occupies four consecutive words:

| Word | Contents |
|------|----------|
| +0 | Buffer byte address, bits 15:0 |
| +1 | Control and status in bits 15:8; buffer address bits 23:16 in bits 7:0 |
| +2 | Negated byte count |
| +3 | Error word |

The ring holds 2^k entries. The value k is taken from bits 7:5 of a length byte.

Top module: `txdesc_ring_engine`

## Requirements
- R1: After reset, mem_rd, mem_we, tx_valid, tx_last and tx_done are all 0.
- R2: While the engine is running and idle, a tx_demand pulse reads word +1 of the current descriptor. If bit 15 of that word (ownership, 1 = engine owns) is 0, no byte is sent, nothing is written, and the engine waits for the next demand.
- R3: For an owned descriptor, the engine sends L bytes on tx_data with tx_valid high, and raises tx_last with the final byte. L is decoded from word +2, which holds the two's complement of L in bits 11:0 with bits 15:12 all ones, where 1 <= L <= 4095. The buffer byte address is {word1[7:0], word0} and is even. Byte j comes from the 16-bit word at byte address + j: bits 7:0 when j is even, bits 15:8 when j is odd.
- R4: When auto_pad is 1 and L < 60, the frame is extended with zero bytes to exactly 60 bytes. Otherwise exactly L bytes are sent.
- R5: After the final byte, word +1 is written back with bits 15:10 cleared and bits 9:0 kept, and word +3 is written with 0. tx_done pulses for exactly one cycle, in the cycle after the cycle in which tx_last was high.
- R6: After each frame, the index advances modulo 2^k, where k = ring_len_code[7:5], and the next descriptor is checked without a new demand. After the last entry, the index wraps to entry 0.
- R7: A cmd_start pulse sets running and resets the index to entry 0.
- R8: A cmd_stop pulse clears running and aborts any frame in progress. tx_demand is then ignored, with no memory access and no bytes sent, until cmd_start. If both pulse in the same cycle, cmd_stop wins.
- R9: Word w of descriptor i is at memory word ring_base + 4*i + w. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | AW | Word address of descriptor 0 |
| ring_len_code | input | 8 | Ring size byte; bits 7:5 hold log2 of the entry count |
| auto_pad | input | 1 | Pad short frames to 60 bytes |
| cmd_start | input | 1 | Start pulse; resets the index |
| cmd_stop | input | 1 | Stop pulse |
| tx_demand | input | 1 | Poll request pulse |
| mem_rd | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rvalid | input | 1 | Read data valid pulse |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_done | output | 1 | One-cycle frame-complete event |

## Verification
The first memory read follows a demand by one clock. Bytes then arrive two per fetched word, with a short gap while each read returns. tx_done is due exactly one cycle after the cycle that carried tx_last. The monitor samples on falling edges and compares bytes strictly in order against the queued expectation, so gaps cannot cause false mismatches. It checks each tx_done against the tx_last flag sampled in the previous cycle. Descriptor write-backs and ignored demands are checked in memory only after a bounded wait for the expected number of done events, or after a fixed quiet period of 30 to 40 cycles.

// File: rtl/tdre_pkg.sv
package tdre_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OWN, ST_ADDR, ST_CNT, ST_DATA, ST_EMIT, ST_STAT, ST_NEXT
  } eng_st_t;

  localparam logic [1:0] WD_ADDR = 2'd0;
  localparam logic [1:0] WD_STAT = 2'd1;
  localparam logic [1:0] WD_CNT  = 2'd2;
  localparam logic [1:0] WD_ERR  = 2'd3;
  localparam int OWN_BIT = 15;
endpackage

// File: rtl/tdre_len_decode.sv
module tdre_len_decode #(
  parameter int CW      = 12,
  parameter int MIN_LEN = 60
) (
  input  logic [15:0]   cnt_word,
  input  logic          pad_en,
  output logic [CW-1:0] data_len,
  output logic [CW-1:0] send_len
);
  always_comb begin
    data_len = CW'(~cnt_word[CW-1:0]) + CW'(1);
    if (pad_en && (data_len < CW'(MIN_LEN)))
      send_len = CW'(MIN_LEN);
    else
      send_len = data_len;
  end
endmodule

// File: rtl/tdre_byte_lane.sv
module tdre_byte_lane #(
  parameter int CW = 12
) (
  input  logic [15:0]   word_in,
  input  logic [CW-1:0] byte_idx,
  input  logic [CW-1:0] data_len,
  output logic [7:0]    byte_out
);
  always_comb begin
    if (byte_idx >= data_len)
      byte_out = 8'h00;
    else if (byte_idx[0])
      byte_out = word_in[15:8];
    else
      byte_out = word_in[7:0];
  end
endmodule

// File: rtl/tdre_ring_index.sv
module tdre_ring_index #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          advance,
  input  logic [2:0]    size_code,
  output logic [IW-1:0] idx
);
  logic [IW:0]   span;
  logic [IW-1:0] mask;

  always_comb begin
    span = (IW+1)'(1) << size_code;
    mask = IW'(span - (IW+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clear)
      idx <= '0;
    else if (advance)
      idx <= (idx + IW'(1)) & mask;
  end

  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear && idx == mask) |=> (idx == '0)); // R6
endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine
  import tdre_pkg::*;
#(
  parameter int AW      = 23,
  parameter int CW      = 12,
  parameter int MIN_LEN = 60,
  parameter int IW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ring_base,
  input  logic [7:0]    ring_len_code,
  input  logic          auto_pad,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          tx_demand,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_rvalid,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_done
);
  eng_st_t       st;
  logic          running;
  logic [15:0]   stat_q, alo_q, cnt_q, dbuf_q;
  logic [CW-1:0] bcnt, nxt, data_len, send_len;
  logic [7:0]    lane_byte;
  logic [IW-1:0] idx;
  logic [AW-1:0] desc_base, buf_word;
  logic [23:0]   buf_byte;
  logic          idx_clear, idx_adv;

  assign idx_clear = cmd_start && !cmd_stop;
  assign idx_adv   = (st == ST_STAT) && !cmd_stop && !cmd_start;
  assign nxt       = bcnt + CW'(1);
  assign desc_base = ring_base + AW'({idx, 2'b00});
  assign buf_byte  = {stat_q[7:0], alo_q};
  assign buf_word  = AW'(buf_byte[23:1]);

  tdre_ring_index #(.IW(IW)) u_index (
    .clk(clk), .rst(rst), .clear(idx_clear), .advance(idx_adv),
    .size_code(ring_len_code[7:5]), .idx(idx)
  );

  tdre_len_decode #(.CW(CW), .MIN_LEN(MIN_LEN)) u_len (
    .cnt_word(cnt_q), .pad_en(auto_pad), .data_len(data_len), .send_len(send_len)
  );

  tdre_byte_lane #(.CW(CW)) u_lane (
    .word_in(dbuf_q), .byte_idx(bcnt), .data_len(data_len), .byte_out(lane_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      running   <= 1'b0;
      mem_rd    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_last   <= 1'b0;
      tx_done   <= 1'b0;
      stat_q    <= '0;
      alo_q     <= '0;
      cnt_q     <= '0;
      dbuf_q    <= '0;
      bcnt      <= '0;
    end else begin
      mem_rd   <= 1'b0;
      mem_we   <= 1'b0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      tx_done  <= 1'b0;
      if (cmd_stop) begin
        running <= 1'b0;
        st      <= ST_IDLE;
      end else if (cmd_start) begin
        running <= 1'b1;
        st      <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: if (running && tx_demand) begin
            mem_rd   <= 1'b1;
            mem_addr <= desc_base + AW'(WD_STAT);
            st       <= ST_OWN;
          end
          ST_OWN: if (mem_rvalid) begin
            stat_q <= mem_rdata;
            if (mem_rdata[OWN_BIT]) begin
              mem_rd   <= 1'b1;
              mem_addr <= desc_base + AW'(WD_ADDR);
              st       <= ST_ADDR;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_ADDR: if (mem_rvalid) begin
            alo_q    <= mem_rdata;
            mem_rd   <= 1'b1;
            mem_addr <= desc_base + AW'(WD_CNT);
            st       <= ST_CNT;
          end
          ST_CNT: if (mem_rvalid) begin
            cnt_q    <= mem_rdata;
            bcnt     <= '0;
            mem_rd   <= 1'b1;
            mem_addr <= buf_word;
            st       <= ST_DATA;
          end
          ST_DATA: if (mem_rvalid) begin
            dbuf_q <= mem_rdata;
            st     <= ST_EMIT;
          end
          ST_EMIT: begin
            tx_valid <= 1'b1;
            tx_data  <= lane_byte;
            bcnt     <= nxt;
            if (bcnt == send_len - CW'(1)) begin
              tx_last   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= desc_base + AW'(WD_STAT);
              mem_wdata <= {6'b0, stat_q[9:0]};
              st        <= ST_STAT;
            end else if (!nxt[0] && (nxt < data_len)) begin
              mem_rd   <= 1'b1;
              mem_addr <= buf_word + AW'(nxt[CW-1:1]);
              st       <= ST_DATA;
            end
          end
          ST_STAT: begin
            mem_we    <= 1'b1;
            mem_addr  <= desc_base + AW'(WD_ERR);
            mem_wdata <= 16'h0000;
            tx_done   <= 1'b1;
            st        <= ST_NEXT;
          end
          ST_NEXT: begin
            mem_rd   <= 1'b1;
            mem_addr <= desc_base + AW'(WD_STAT);
            st       <= ST_OWN;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we)); // R9
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> (!mem_rd && !mem_we && !tx_valid && !tx_done)); // R8
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> $past(tx_last)); // R5
endmodule

// File: tb/txdesc_ring_engine_test.sv
module txdesc_ring_engine_test;
  localparam int AW = 23;
  localparam logic [AW-1:0] RBASE = AW'(24'h000100);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] ring_base = RBASE;
  logic [7:0] ring_len_code = 8'h40;
  logic auto_pad = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0, tx_demand = 1'b0;
  logic mem_rd, mem_we, mem_rvalid, tx_valid, tx_last, tx_done;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0] tx_data;

  logic [15:0] mem [0:4095];
  logic [8:0] exp_q [$];
  int n_chk = 0, n_fail = 0, done_cnt = 0;
  logic prev_last = 1'b0;

  always #10 clk = ~clk;

  txdesc_ring_engine #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .ring_base(ring_base), .ring_len_code(ring_len_code),
    .auto_pad(auto_pad), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .tx_demand(tx_demand), .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_done(tx_done)
  );

  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected bytes in order, checks done timing
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid) begin
        if (exp_q.size() == 0) begin
          check("R2/R8 unexpected byte", {23'b0, tx_last, tx_data}, 32'h1ff);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check("R3/R4 frame byte", {23'b0, tx_last, tx_data}, {23'b0, e});
        end
      end
      if (tx_done) begin
        done_cnt++;
        check("R5 done follows last", {31'b0, prev_last}, 32'd1);
      end
      prev_last <= tx_valid && tx_last;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int j);
    return 8'((seed * 31 + j * 7 + 1) & 8'hff);
  endfunction

  function automatic int dw(input int i, input int w);
    return int'(RBASE) + 4 * i + w;
  endfunction

  task automatic load_desc(input int i, input int len, input int seed, input bit own);
    int baddr;
    baddr = 24'h001000 + i * 24'h100;
    @(negedge clk);
    for (int j = 0; j < len; j++) begin
      if (j % 2 == 0) mem[(baddr / 2 + j / 2) % 4096][7:0] = pat(seed, j);
      else            mem[(baddr / 2 + j / 2) % 4096][15:8] = pat(seed, j);
    end
    mem[dw(i, 0)] = 16'(baddr);
    mem[dw(i, 1)] = (own ? 16'h9300 : 16'h1300) | 16'((baddr >> 16) & 8'hff);
    mem[dw(i, 2)] = 16'hF000 | 16'((-len) & 12'hfff);
    mem[dw(i, 3)] = 16'hABCD;
  endtask

  task automatic expect_frame(input int len, input int seed, input bit pad);
    int tot;
    tot = (pad && len < 60) ? 60 : len;
    for (int j = 0; j < tot; j++)
      exp_q.push_back({(j == tot - 1), (j < len) ? pat(seed, j) : 8'h00});
  endtask

  task automatic pulse_demand();
    @(negedge clk); tx_demand = 1'b1;
    @(negedge clk); tx_demand = 1'b0;
  endtask
  task automatic pulse_start();
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); cmd_stop = 1'b1;
    @(negedge clk); cmd_stop = 1'b0;
  endtask

  task automatic wait_dones(input int target, input string req);
    int t;
    t = 0;
    while (done_cnt < target && t < 3000) begin
      @(negedge clk); t++;
    end
    repeat (8) @(negedge clk);
    check(req, done_cnt, target);
  endtask

  task automatic check_wb(input int i, input string req);
    check(req, {16'b0, mem[dw(i, 1)]}, 32'h0300);
    check(req, {16'b0, mem[dw(i, 3)]}, 32'h0000);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_test();
  end

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 16'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", {27'b0, mem_rd, mem_we, tx_valid, tx_last, tx_done}, 32'd0);

    pulse_start();
    load_desc(0, 64, 1, 1'b0);
    pulse_demand();
    repeat (30) @(negedge clk);
    check("R2 not owned no done", done_cnt, 0);
    check("R2 not owned untouched", {16'b0, mem[dw(0, 1)]}, 32'h1300);

    load_desc(0, 64, 1, 1'b1);
    expect_frame(64, 1, 1'b0);
    pulse_demand();
    wait_dones(1, "R3 frame 64");
    check_wb(0, "R5 R9 writeback desc0");

    load_desc(1, 7, 2, 1'b1);
    expect_frame(7, 2, 1'b0);
    pulse_demand();
    wait_dones(2, "R3 odd length");
    check_wb(1, "R5 writeback desc1");

    auto_pad = 1'b1;
    load_desc(2, 5, 3, 1'b1);
    expect_frame(5, 3, 1'b1);
    pulse_demand();
    wait_dones(3, "R4 padded frame");

    load_desc(3, 61, 4, 1'b1);
    expect_frame(61, 4, 1'b1);
    pulse_demand();
    wait_dones(4, "R4 no pad above min");

    load_desc(0, 3, 5, 1'b1);
    expect_frame(3, 5, 1'b1);
    pulse_demand();
    wait_dones(5, "R6 wrap to entry 0");
    check_wb(0, "R6 wrap writeback");

    auto_pad = 1'b0;
    load_desc(1, 10, 6, 1'b1);
    load_desc(2, 11, 7, 1'b1);
    expect_frame(10, 6, 1'b0);
    expect_frame(11, 7, 1'b0);
    pulse_demand();
    wait_dones(7, "R6 chained frames");
    check_wb(2, "R6 chain writeback");

    pulse_stop();
    load_desc(3, 9, 8, 1'b1);
    pulse_demand();
    repeat (40) @(negedge clk);
    check("R8 stopped no done", done_cnt, 7);
    check("R8 stopped untouched", {16'b0, mem[dw(3, 1)]}, 32'h9300);

    pulse_start();
    load_desc(0, 12, 9, 1'b1);
    expect_frame(12, 9, 1'b0);
    pulse_demand();
    wait_dones(8, "R7 start restarts at 0");
    check_wb(0, "R7 desc0 used");
    check("R7 desc3 skipped", {16'b0, mem[dw(3, 1)]}, 32'h9300);
    check("R3 queue drained", exp_q.size(), 0);
    finish_test();
  end
endmodule